// File: doc/BRIEF.md
# Dual-Mode Serial Character Receiver

This block takes a serial input line and turns it into 8-bit characters. It has two modes. In the oversampled mode a clock enable runs at sixteen times the bit rate. A falling edge has to stay low long enough to count as a start bit, and each following bit is then sampled at its centre. In the clocked mode a one-cycle enable marks each rising edge of an external bit clock, and the line is sampled once per enable. Before any sampling logic, the line passes through a two-stage synchronizer.

A completed character moves into a holding register and raises a ready flag. The block also keeps three sticky error flags: overrun, parity mismatch and a framing fault on the stop bit. The surrounding logic empties the holding register with a read strobe. It clears the error flags with a separate status-clear strobe. Bit-rate generation, the transmitter, register decoding and interrupts are all outside this block.

Top module: `dual_serial_rx`

## Requirements
- R1: `mode_sync` = 0 selects oversampled operation, which is paced by `os_tick` (16 ticks per bit). `mode_sync` = 1 selects clocked operation, which is paced by `bit_tick`. The enable of the mode not selected is ignored.
- R2: In oversampled mode a start bit is accepted only after more than 7 consecutive `os_tick` samples of a low line. A low pulse of 7 samples or fewer is dropped, and no character follows.
- R3: In oversampled mode, data bit 0 is sampled 24 ticks after the first low tick. Each later bit (data, parity, stop) is sampled 16 ticks after the one before. There are 8 data bits, received least significant bit first.
- R4: In clocked mode, the first `bit_tick` that sees a low line is the start bit. The next `bit_tick` samples carry data bits 0..7, then the parity bit if one is enabled, then the stop bit.
- R5: `par_mode` encoding: 2'b00 = no parity bit, 2'b01 = even, 2'b10 = odd, 2'b11 = no parity bit. When parity is enabled, a received parity bit that differs from the computed one sets `rx_par_err`.
- R6: `rx_frm_err` is set when the stop bit samples low and at least one data bit is high. A character of all zeros with a low stop bit sets no error.
- R7: When a character completes, `rx_data` takes its value and `rx_ready` rises.
- R8: If a character completes while `rx_ready` is still set, `rx_overrun` is set. `rx_data` takes the newer character.
- R9: `rd_strobe` clears `rx_ready` only. `clr_strobe` clears `rx_overrun`, `rx_par_err` and `rx_frm_err`. A completion in the same cycle as either strobe wins.
- R10: After reset the receiver is idle, `rx_data` is zero and all flags are low.
- R11: After a stop bit samples low, no new start bit is accepted until the line has been sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input, idle high |
| mode_sync | input | 1 | 0 = oversampled, 1 = clocked |
| par_mode | input | 2 | Parity selection |
| os_tick | input | 1 | 16x bit-rate sample enable |
| bit_tick | input | 1 | Rising-edge marker of the bit clock |
| rd_strobe | input | 1 | Holding register read |
| clr_strobe | input | 1 | Clears the error flags |
| rx_data | output | 8 | Holding register |
| rx_ready | output | 1 | Character available |
| rx_overrun | output | 1 | Character lost, sticky |
| rx_par_err | output | 1 | Parity mismatch, sticky |
| rx_frm_err | output | 1 | Stop-bit fault, sticky |

## Verification
A change on `rx_line` reaches the sampling logic two edges later, after the synchronizer. The stop-bit sample registers a completion on the following edge, and the holding register and flags update one edge after that. The stop bit is sampled mid-bit, so its results are due well before the stop-bit period ends. The bench therefore reads them at a falling edge after the whole frame and some idle time. Strobes act on the next rising edge, and the bench reads their effect at the falling edge that follows. The start-bit qualification test holds the line low for 7 and for 8 cycles, with `os_tick` active every cycle.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_QUAL,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_HUNT
    } rx_state_e;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_RSVD = 2'b11
    } par_mode_e;

endpackage

// File: rtl/dsr_sync.sv
module dsr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] ff_d, ff_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb ff_d = din;
        end else begin : g_many
            always_comb ff_d = {ff_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '1;
        else        ff_q <= ff_d;
    end

    assign dout = ff_q[STAGES-1];
endmodule

// File: rtl/dsr_framer.sv
module dsr_framer
    import dsr_pkg::*;
#(
    parameter int DW        = 8,
    parameter int OS_RATIO  = 16,
    parameter int START_MIN = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx,
    input  logic          mode_sync,
    input  logic [1:0]    par_mode,
    input  logic          os_tick,
    input  logic          bit_tick,
    output logic          done,
    output logic [DW-1:0] char_out,
    output logic          perr,
    output logic          ferr
);
    localparam int HALF = OS_RATIO / 2;
    localparam int CW   = $clog2(OS_RATIO + HALF + 1);
    localparam int IW   = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [CW-1:0] QUAL_LAST = CW'(START_MIN - 2);
    localparam logic [CW-1:0] RELOAD0   = CW'(OS_RATIO + HALF - START_MIN);
    localparam logic [CW-1:0] RELOAD    = CW'(OS_RATIO - 1);
    localparam logic [IW-1:0] IDX_LAST  = IW'(DW - 1);

    typedef struct packed {
        rx_state_e     st;
        logic [CW-1:0] cnt;
        logic [IW-1:0] idx;
        logic [DW-1:0] sh;
        logic          pbit;
        logic          done;
        logic          perr;
        logic          ferr;
    } fr_t;

    fr_t q, d;

    logic tick_os, samp, par_on, exp_par, any_tick;

    always_comb begin
        tick_os  = !mode_sync && os_tick;
        samp     = mode_sync ? bit_tick : (tick_os && q.cnt == '0);
        any_tick = mode_sync ? bit_tick : os_tick;
        par_on   = (par_mode == PAR_EVEN) || (par_mode == PAR_ODD);
        exp_par  = (^q.sh) ^ (par_mode == PAR_ODD);

        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (mode_sync) begin
                    if (bit_tick && !rx) begin
                        d.st  = ST_DATA;
                        d.idx = '0;
                    end
                end else if (os_tick && !rx) begin
                    d.st  = ST_QUAL;
                    d.cnt = '0;
                end
            end
            ST_QUAL: begin
                if (os_tick) begin
                    if (rx) begin
                        d.st = ST_IDLE;
                    end else if (q.cnt == QUAL_LAST) begin
                        d.st  = ST_DATA;
                        d.cnt = RELOAD0;
                        d.idx = '0;
                    end else begin
                        d.cnt = q.cnt + CW'(1);
                    end
                end
            end
            ST_DATA: begin
                if (samp) begin
                    d.sh  = {rx, q.sh[DW-1:1]};
                    d.cnt = RELOAD;
                    if (q.idx == IDX_LAST) d.st = par_on ? ST_PAR : ST_STOP;
                    else                   d.idx = q.idx + IW'(1);
                end else if (tick_os) begin
                    d.cnt = q.cnt - CW'(1);
                end
            end
            ST_PAR: begin
                if (samp) begin
                    d.pbit = rx;
                    d.cnt  = RELOAD;
                    d.st   = ST_STOP;
                end else if (tick_os) begin
                    d.cnt = q.cnt - CW'(1);
                end
            end
            ST_STOP: begin
                if (samp) begin
                    d.done = 1'b1;
                    d.perr = par_on && (q.pbit != exp_par);
                    d.ferr = !rx && (|q.sh);
                    d.st   = rx ? ST_IDLE : ST_HUNT;
                end else if (tick_os) begin
                    d.cnt = q.cnt - CW'(1);
                end
            end
            ST_HUNT: begin
                if (any_tick && rx) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign done     = q.done;
    assign char_out = q.sh;
    assign perr     = q.perr;
    assign ferr     = q.ferr;

    rx_state_e st_q;
    assign st_q = q.st;

    p_qual_async_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_QUAL && $past(st_q) == ST_IDLE) |-> (!$past(mode_sync) && !$past(rx)));

    p_qual_len_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DATA && $past(st_q) == ST_QUAL) |-> ($past(q.cnt) == QUAL_LAST && !$past(rx)));

    p_sync_start_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DATA && $past(st_q) == ST_IDLE) |-> ($past(mode_sync) && $past(bit_tick)));

    p_hunt_exit_r11 : assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && $past(st_q) == ST_HUNT) |-> $past(rx));
endmodule

// File: rtl/dsr_status.sv
module dsr_status #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done,
    input  logic [DW-1:0] char_in,
    input  logic          perr_in,
    input  logic          ferr_in,
    input  logic          rd,
    input  logic          clr,
    output logic [DW-1:0] data,
    output logic          rdy,
    output logic          ovr,
    output logic          perr,
    output logic          ferr
);
    typedef struct packed {
        logic [DW-1:0] data;
        logic          rdy;
        logic          ovr;
        logic          perr;
        logic          ferr;
    } st_t;

    st_t q, d;

    always_comb begin
        d = q;
        if (rd) d.rdy = 1'b0;
        if (clr) begin
            d.ovr  = 1'b0;
            d.perr = 1'b0;
            d.ferr = 1'b0;
        end
        if (done) begin
            d.data = char_in;
            d.rdy  = 1'b1;
            if (q.rdy && !rd) d.ovr  = 1'b1;
            if (perr_in)      d.perr = 1'b1;
            if (ferr_in)      d.ferr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign data = q.data;
    assign rdy  = q.rdy;
    assign ovr  = q.ovr;
    assign perr = q.perr;
    assign ferr = q.ferr;

    p_done_loads_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (rdy && data == $past(char_in)));

    p_ovr_cause_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> ($past(rdy) && $past(done)));

    p_rd_clears_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !done) |=> !rdy);

    p_clr_clears_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !done) |=> (!ovr && !perr && !ferr));

    p_ferr_data_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ferr) |-> (data != '0));
endmodule

// File: rtl/dual_serial_rx.sv
module dual_serial_rx #(
    parameter int DW          = 8,
    parameter int OS_RATIO    = 16,
    parameter int START_MIN   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_line,
    input  logic          mode_sync,
    input  logic [1:0]    par_mode,
    input  logic          os_tick,
    input  logic          bit_tick,
    input  logic          rd_strobe,
    input  logic          clr_strobe,
    output logic [DW-1:0] rx_data,
    output logic          rx_ready,
    output logic          rx_overrun,
    output logic          rx_par_err,
    output logic          rx_frm_err
);
    logic          rx_s;
    logic          fr_done, fr_perr, fr_ferr;
    logic [DW-1:0] fr_char;

    dsr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_line),
        .dout (rx_s)
    );

    dsr_framer #(.DW(DW), .OS_RATIO(OS_RATIO), .START_MIN(START_MIN)) u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx       (rx_s),
        .mode_sync(mode_sync),
        .par_mode (par_mode),
        .os_tick  (os_tick),
        .bit_tick (bit_tick),
        .done     (fr_done),
        .char_out (fr_char),
        .perr     (fr_perr),
        .ferr     (fr_ferr)
    );

    dsr_status #(.DW(DW)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .done   (fr_done),
        .char_in(fr_char),
        .perr_in(fr_perr),
        .ferr_in(fr_ferr),
        .rd     (rd_strobe),
        .clr    (clr_strobe),
        .data   (rx_data),
        .rdy    (rx_ready),
        .ovr    (rx_overrun),
        .perr   (rx_par_err),
        .ferr   (rx_frm_err)
    );
endmodule

// File: tb/tb_dual_serial_rx.sv
module tb_dual_serial_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       mode_sync = 1'b0;
    logic [1:0] par_mode = 2'b00;
    logic       os_tick = 1'b1;
    logic       bit_tick = 1'b0;
    logic       rd_strobe = 1'b0;
    logic       clr_strobe = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, rx_overrun, rx_par_err, rx_frm_err;

    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    dual_serial_rx dut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .mode_sync(mode_sync),
        .par_mode(par_mode), .os_tick(os_tick), .bit_tick(bit_tick),
        .rd_strobe(rd_strobe), .clr_strobe(clr_strobe), .rx_data(rx_data),
        .rx_ready(rx_ready), .rx_overrun(rx_overrun), .rx_par_err(rx_par_err),
        .rx_frm_err(rx_frm_err)
    );

    // {sync, par[1:0], data[7:0], flip parity, stop level, exp perr, exp ferr}
    localparam logic [14:0] VEC [12] = '{
        {1'b0, 2'b00, 8'hA5, 1'b0, 1'b1, 1'b0, 1'b0},
        {1'b0, 2'b01, 8'h3C, 1'b0, 1'b1, 1'b0, 1'b0},
        {1'b0, 2'b10, 8'h3C, 1'b0, 1'b1, 1'b0, 1'b0},
        {1'b0, 2'b01, 8'h81, 1'b1, 1'b1, 1'b1, 1'b0},
        {1'b0, 2'b10, 8'h7F, 1'b1, 1'b1, 1'b1, 1'b0},
        {1'b0, 2'b00, 8'h55, 1'b0, 1'b0, 1'b0, 1'b1},
        {1'b0, 2'b00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0},
        {1'b0, 2'b11, 8'hC3, 1'b1, 1'b1, 1'b0, 1'b0},
        {1'b1, 2'b00, 8'h96, 1'b0, 1'b1, 1'b0, 1'b0},
        {1'b1, 2'b01, 8'h01, 1'b1, 1'b1, 1'b1, 1'b0},
        {1'b1, 2'b10, 8'hF0, 1'b0, 1'b0, 1'b0, 1'b1},
        {1'b1, 2'b00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put_bit(input logic v);
        rx_line = v;
        if (mode_sync) begin
            repeat (2) @(negedge clk);
            bit_tick = 1'b1;
            @(negedge clk);
            bit_tick = 1'b0;
            @(negedge clk);
        end else begin
            repeat (16) @(negedge clk);
        end
    endtask

    task automatic send(input logic [7:0] dat, input logic flip, input logic stop);
        logic pb;
        put_bit(1'b0);
        for (int i = 0; i < 8; i++) put_bit(dat[i]);
        pb = (^dat) ^ (par_mode == 2'b10) ^ flip;
        if (par_mode == 2'b01 || par_mode == 2'b10) put_bit(pb);
        put_bit(stop);
        rx_line = 1'b1;
        if (mode_sync) begin
            put_bit(1'b1);
            put_bit(1'b1);
        end
        repeat (20) @(negedge clk);
    endtask

    task automatic pulse_rd;
        rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_clr;
        clr_strobe = 1'b1; @(negedge clk); clr_strobe = 1'b0; @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R10: reset state
        chk("R10 data", {24'd0, rx_data}, 32'h0);
        chk("R10 ready", {31'd0, rx_ready}, 32'd0);
        chk("R10 overrun", {31'd0, rx_overrun}, 32'd0);
        chk("R10 parity", {31'd0, rx_par_err}, 32'd0);
        chk("R10 framing", {31'd0, rx_frm_err}, 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        for (int k = 0; k < 12; k++) begin
            logic [14:0] v;
            v = VEC[k];
            mode_sync = v[14];
            par_mode  = v[13:12];
            repeat (4) @(negedge clk);
            send(v[11:4], v[3], v[2]);
            chk(v[14] ? "R1 R4 data" : "R1 R3 data", {24'd0, rx_data}, {24'd0, v[11:4]});
            chk("R7 ready", {31'd0, rx_ready}, 32'd1);
            chk("R5 parity", {31'd0, rx_par_err}, {31'd0, v[1]});
            chk("R6 framing", {31'd0, rx_frm_err}, {31'd0, v[0]});
            chk("R8 no overrun", {31'd0, rx_overrun}, 32'd0);
            pulse_rd;
            chk("R9 read clears ready", {31'd0, rx_ready}, 32'd0);
            chk("R9 read keeps errors", {30'd0, rx_par_err, rx_frm_err}, {30'd0, v[1], v[0]});
            pulse_clr;
            chk("R9 clear errors", {30'd0, rx_par_err, rx_frm_err}, 32'd0);
        end

        // R2: 7-tick low pulse is dropped, 8-tick low pulse starts a character
        mode_sync = 1'b0;
        par_mode  = 2'b00;
        rx_line = 1'b0; repeat (7) @(negedge clk); rx_line = 1'b1;
        repeat (200) @(negedge clk);
        chk("R2 short pulse ignored", {31'd0, rx_ready}, 32'd0);
        rx_line = 1'b0; repeat (8) @(negedge clk); rx_line = 1'b1;
        repeat (200) @(negedge clk);
        chk("R2 long pulse accepted", {31'd0, rx_ready}, 32'd1);
        chk("R2 long pulse data", {24'd0, rx_data}, 32'hFF);
        pulse_rd;
        pulse_clr;

        // R8: two characters with no read in between
        send(8'h11, 1'b0, 1'b1);
        send(8'h22, 1'b0, 1'b1);
        chk("R8 overrun set", {31'd0, rx_overrun}, 32'd1);
        chk("R8 newer data", {24'd0, rx_data}, 32'h22);
        pulse_rd;
        chk("R9 read leaves overrun", {31'd0, rx_overrun}, 32'd1);
        chk("R9 read clears ready", {31'd0, rx_ready}, 32'd0);
        pulse_clr;
        chk("R9 clear overrun", {31'd0, rx_overrun}, 32'd0);

        // R11: line stays low after a low stop bit; no second start until high
        put_bit(1'b0);
        for (int i = 0; i < 8; i++) put_bit(i[0] ? 1'b0 : 1'b1);
        rx_line = 1'b0;
        repeat (64) @(negedge clk);
        rx_line = 1'b1;
        repeat (200) @(negedge clk);
        chk("R11 data", {24'd0, rx_data}, 32'h55);
        chk("R11 framing", {31'd0, rx_frm_err}, 32'd1);
        chk("R11 no extra character", {31'd0, rx_overrun}, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule